// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that sits between two clock domains. A producer pushes 9-bit words on its write clock, and a consumer pulls them on its own read clock. The two clocks may be unrelated or may be the same net. Each side sees two status flags. On the write side these are full and almost-full. On the read side they are empty and almost-empty. All four flags are active low. Read data is held in an output register, and a tri-state enable can take that register off the shared output bus.

One input has two meanings, and its level while reset is held low chooses between them. If it is held high during reset, the block runs in expansion mode: the pin becomes a second write qualifier, and a word is stored only when this pin is high and the primary write enable is low. If it is held low during reset, the block runs in threshold mode. In that mode, pulling the pin low together with the primary write enable loads the two threshold registers instead of the buffer. The loads take turns between the empty threshold and the full threshold.

Pointers cross between the domains as Gray code through two-flop synchronizers. A flag therefore clears a couple of cycles after the operation on the other side that clears it. Depth must be a power of two.

Top module: `dcfifo_pflag`

## Requirements
- R1: While rst_n is low and after it rises: full_n and afull_n read 1, empty_n and aempty_n read 0, and the output register holds all zeros.
- R2: In expansion mode (wen2_ld high during reset), a word is stored on a rising wclk only when wen1_n is 0 and wen2_ld is 1. With wen2_ld low, nothing is stored and the thresholds do not change.
- R3: In threshold mode (wen2_ld low during reset), wen1_n low with wen2_ld high stores a word. wen1_n low with wen2_ld low stores no word and loads a threshold instead.
- R4: Threshold loads take din[AW-1:0], where AW = log2(DEPTH). The first load after reset sets the empty threshold, the next sets the full threshold, and the pattern then repeats from the empty threshold.
- R5: A word moves to the output register on a rising rclk only when ren1_n and ren2_n are both 0. Otherwise the register keeps its value. Words leave in the order they were written.
- R6: Write attempts are ignored while the buffer is full. Read attempts are ignored while it is empty, and the output register stays unchanged.
- R7: full_n is 0 exactly when DEPTH words are held, and empty_n is 0 exactly when none are held. With coincident clocks, empty_n rises by the third rclk edge after a write into an empty buffer.
- R8: aempty_n is 0 when the stored count is at or below the empty threshold, and 1 above it.
- R9: afull_n is 0 when the free space (DEPTH minus count) is at or below the full threshold, and 1 above it.
- R10: With oe_n high, the dout bus is high-impedance. With oe_n low, it drives the output register.
- R11: Both thresholds reset to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Reset, active low; also the window in which the mode is sampled |
| din | input | 9 | Write data |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write qualifier (expansion mode) or threshold-load strobe, active low (threshold mode) |
| ren1_n | input | 1 | Read enable one, active low |
| ren2_n | input | 1 | Read enable two, active low |
| oe_n | input | 1 | Output enable for dout, active low |
| dout | output | 9 | Read data, tri-stated when oe_n is high |
| full_n | output | 1 | Full flag, active low, wclk domain |
| afull_n | output | 1 | Almost-full flag, active low, wclk domain |
| empty_n | output | 1 | Empty flag, active low, rclk domain |
| aempty_n | output | 1 | Almost-empty flag, active low, rclk domain |

## Verification
A seeded random sequence mixes every combination of write and read enable levels, so each single-enable case is shown to differ from an accepted transfer. Directed fills step the buffer one word at a time across the almost-empty, almost-full and full boundaries. This is done both with the default thresholds and with loaded ones, which separates a threshold compare that is off by one from a correct one. Low-strobe writes are attempted in both modes, and each time the count is placed right next to a threshold. That tells a true expansion-mode no-op apart from a stray threshold load or a stray store. Back-to-back bursts check that the synchronized pointers never accept more or fewer words than the model expects.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    typedef enum logic {
        MODE_EXPAND = 1'b0,
        MODE_PROG   = 1'b1
    } fifo_mode_e;

    typedef enum logic {
        OSEL_EMPTY = 1'b0,
        OSEL_FULL  = 1'b1
    } ofs_sel_e;

    localparam int DEF_OFFSET = 7;
endpackage

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a Gray pointer, followed by a Gray-to-binary conversion.
module dcf_ptr_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = gray_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_o[i] = ^sync_q.s2[W-1:i];
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
// Write side: pointer, mode latch, threshold registers, full flags.
module dcf_wr_ctrl #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic [AW-1:0] ofs_din,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [PW-1:0] rbin_sync,
    output logic          wr_en,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] eofs,
    output logic          mode_prog,
    output logic          full_n,
    output logic          afull_n
);
    import dcf_pkg::*;

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [AW-1:0] eofs;
        logic [AW-1:0] fofs;
        ofs_sel_e      sel;
    } wstate_t;

    wstate_t    st_d, st_q;
    fifo_mode_e mode_q;
    logic [PW-1:0] count, space;
    logic          is_full, wr_ok, ofs_wr;

    // The mode is captured on every wclk edge while reset is low.
    always_ff @(posedge wclk) begin
        if (!rst_n) mode_q <= wen2_ld ? MODE_EXPAND : MODE_PROG;
    end

    always_comb begin
        count   = st_q.bin - rbin_sync;
        space   = DEPTH_P - count;
        is_full = (count == DEPTH_P);
        wr_ok   = !wen1_n && wen2_ld && !is_full;
        ofs_wr  = (mode_q == MODE_PROG) && !wen1_n && !wen2_ld;

        st_d = st_q;
        if (wr_ok) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = (st_d.bin >> 1) ^ st_d.bin;
        end
        if (ofs_wr) begin
            if (st_q.sel == OSEL_EMPTY) st_d.eofs = ofs_din;
            else                        st_d.fofs = ofs_din;
            st_d.sel = (st_q.sel == OSEL_EMPTY) ? OSEL_FULL : OSEL_EMPTY;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bin  <= '0;
            st_q.gray <= '0;
            st_q.eofs <= AW'(DEF_OFFSET);
            st_q.fofs <= AW'(DEF_OFFSET);
            st_q.sel  <= OSEL_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en     = wr_ok;
    assign waddr     = st_q.bin[AW-1:0];
    assign wgray     = st_q.gray;
    assign eofs      = st_q.eofs;
    assign mode_prog = (mode_q == MODE_PROG);
    assign full_n    = !is_full;
    assign afull_n   = !(space <= {1'b0, st_q.fofs});
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
// Read side: pointer, output register, empty flags.
module dcf_rd_ctrl #(
    parameter int DW    = 9,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic [PW-1:0] wbin_sync,
    input  logic [DW-1:0] rdata,
    input  logic [AW-1:0] eofs,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] dout_q,
    output logic          empty_n,
    output logic          aempty_n
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [DW-1:0] dout;
    } rstate_t;

    rstate_t st_d, st_q;
    logic [PW-1:0] count;
    logic          is_empty, rd_ok;

    always_comb begin
        count    = wbin_sync - st_q.bin;
        is_empty = (count == '0);
        rd_ok    = !ren1_n && !ren2_n && !is_empty;

        st_d = st_q;
        if (rd_ok) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = (st_d.bin >> 1) ^ st_d.bin;
            st_d.dout = rdata;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr    = st_q.bin[AW-1:0];
    assign rgray    = st_q.gray;
    assign dout_q   = st_q.dout;
    assign empty_n  = !is_empty;
    assign aempty_n = count > {1'b0, eofs};
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag #(
    parameter int DW    = 9,
    parameter int DEPTH = 256
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          afull_n,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic          wr_en, mode_prog;
    logic [AW-1:0] waddr, raddr, eofs;
    logic [PW-1:0] wgray, rgray, wbin_sync, rbin_sync;
    logic [DW-1:0] rdata, dout_q;

    always_ff @(posedge wclk) begin
        if (wr_en) mem[waddr] <= din;
    end
    assign rdata = mem[raddr];

    dcf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .ofs_din(din[AW-1:0]),
        .wen1_n(wen1_n), .wen2_ld(wen2_ld), .rbin_sync(rbin_sync),
        .wr_en(wr_en), .waddr(waddr), .wgray(wgray), .eofs(eofs),
        .mode_prog(mode_prog), .full_n(full_n), .afull_n(afull_n)
    );

    dcf_rd_ctrl #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .wbin_sync(wbin_sync), .rdata(rdata), .eofs(eofs),
        .raddr(raddr), .rgray(rgray), .dout_q(dout_q),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    dcf_ptr_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_i(wgray), .bin_o(wbin_sync)
    );

    dcf_ptr_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_i(rgray), .bin_o(rbin_sync)
    );

    assign dout = oe_n ? {DW{1'bz}} : dout_q;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
`timescale 1ns/1ps
module dcfifo_pflag_chk #(
    parameter int DW = 9,
    parameter int PW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wen2_ld,
    input logic          ren1_n,
    input logic          ren2_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic          mode_prog,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray,
    input logic [DW-1:0] dout_q
);
    p_no_overflow_r6: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wgray));

    p_no_underflow_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> $stable(rgray));

    p_out_hold_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren1_n || ren2_n) |=> $stable(dout_q));

    p_expand_gate_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (!mode_prog && !wen2_ld) |=> $stable(wgray));

    p_load_no_store_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        (mode_prog && !wen2_ld) |=> $stable(wgray));

    p_afull_with_full_r9: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    p_aempty_with_empty_r8: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    p_gray_step_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.DW(DW), .PW(PW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen2_ld(wen2_ld),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .full_n(full_n), .afull_n(afull_n),
    .empty_n(empty_n), .aempty_n(aempty_n), .mode_prog(mode_prog),
    .wgray(wgray), .rgray(rgray), .dout_q(dout_q)
);

// File: tb/dcfifo_pflag_bench.sv
`timescale 1ns/1ps
module dcfifo_pflag_bench;
    localparam int DW    = 9;
    localparam int DEPTH = 256;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic          wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
    tri1  [DW-1:0] dout;
    logic          full_n, afull_n, empty_n, aempty_n;

    dcfifo_pflag #(.DW(DW), .DEPTH(DEPTH)) u_dcfifo_pflag (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .din(din),
        .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .oe_n(oe_n), .dout(dout), .full_n(full_n), .afull_n(afull_n),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    logic [DW-1:0] mq[$];
    logic [DW-1:0] exp_dout;
    int  eofs_m, fofs_m, n_chk, n_fail;
    bit  sel_m, prog_m;

    function automatic bit exp_aempty_n(int cnt, int ofs); return cnt > ofs; endfunction
    function automatic bit exp_afull_n(int cnt, int ofs);  return (DEPTH - cnt) > ofs; endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        chk({tag, " dout"},     32'(dout), 32'(exp_dout));
        chk({tag, " full_n"},   32'(full_n), 32'(mq.size() != DEPTH));
        chk({tag, " empty_n"},  32'(empty_n), 32'(mq.size() != 0));
        chk({tag, " afull_n"},  32'(afull_n), 32'(exp_afull_n(mq.size(), fofs_m)));
        chk({tag, " aempty_n"}, 32'(aempty_n), 32'(exp_aempty_n(mq.size(), eofs_m)));
    endtask

    task automatic wr_cycle(input bit w1, input bit ld, input logic [DW-1:0] d);
        wen1_n = w1; wen2_ld = ld; din = d;
        if (!w1 && ld && mq.size() < DEPTH) mq.push_back(d);
        else if (prog_m && !w1 && !ld) begin
            if (!sel_m) eofs_m = int'(d[7:0]);
            else        fofs_m = int'(d[7:0]);
            sel_m = !sel_m;
        end
        @(negedge clk);
        wen1_n = 1'b1; wen2_ld = 1'b1;
    endtask

    task automatic rd_cycle(input bit r1, input bit r2);
        ren1_n = r1; ren2_n = r2;
        if (!r1 && !r2 && mq.size() > 0) exp_dout = mq.pop_front();
        @(negedge clk);
        ren1_n = 1'b1; ren2_n = 1'b1;
    endtask

    task automatic do_reset(input bit ld_level);
        @(negedge clk);
        rst_n = 1'b0; wen2_ld = ld_level; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        idle(4);
        chk("R1 in reset full_n", 32'(full_n), 32'd1);
        chk("R1 in reset empty_n", 32'(empty_n), 32'd0);
        rst_n = 1'b1; wen2_ld = 1'b1;
        mq.delete(); exp_dout = '0; eofs_m = 7; fofs_m = 7; sel_m = 1'b0; prog_m = !ld_level;
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        n_chk = 0; n_fail = 0;

        // Expansion mode
        do_reset(1'b1);
        check_state("R1 R11");
        oe_n = 1'b1; idle(1);
        chk("R10 oe_n high floats", 32'(dout), 32'h1FF);
        oe_n = 1'b0; idle(1);
        chk("R10 oe_n low drives", 32'(dout), 32'h000);

        wr_cycle(1'b0, 1'b0, 9'h0AA); idle(3); check_state("R2 ld low no store");
        wr_cycle(1'b1, 1'b1, 9'h0AB); idle(3); check_state("R2 wen1 high no store");
        rd_cycle(1'b0, 1'b0); idle(3); check_state("R6 read on empty");

        for (int i = 1; i <= 8; i++) begin
            wr_cycle(1'b0, 1'b1, DW'(i + 9'h40)); idle(3);
            check_state((i == 1) ? "R7 empty clears" : "R8 R11");
            if (i == 7) begin
                wr_cycle(1'b0, 1'b0, 9'h002); idle(3);
                check_state("R2 ld low leaves thresholds");
            end
        end
        rd_cycle(1'b0, 1'b1); idle(3); check_state("R5 ren2 only high");
        rd_cycle(1'b1, 1'b0); idle(3); check_state("R5 ren1 only high");
        rd_cycle(1'b0, 1'b0); idle(3); check_state("R5 both low");

        // Burst: back to back writes then reads
        for (int i = 0; i < 6; i++) wr_cycle(1'b0, 1'b1, DW'(9'h100 + i));
        idle(3); check_state("R7 burst write");
        for (int i = 0; i < 6; i++) rd_cycle(1'b0, 1'b0);
        idle(3); check_state("R5 burst read order");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 2) == 0)
                wr_cycle(($urandom % 4) == 0, ($urandom % 4) != 0, DW'($urandom));
            else
                rd_cycle(($urandom % 3) == 0, ($urandom % 3) == 0);
            idle(3);
            check_state("R5 random");
        end

        // Drain, fill to full, overflow attempt, drain
        while (mq.size() > 0) begin rd_cycle(1'b0, 1'b0); idle(3); check_state("R5 drain"); end
        for (int i = 0; i < DEPTH; i++) begin
            wr_cycle(1'b0, 1'b1, DW'(i * 3)); idle(3);
            check_state("R9 R7 fill");
        end
        wr_cycle(1'b0, 1'b1, 9'h155); idle(3); check_state("R6 write when full");
        while (mq.size() > 0) begin rd_cycle(1'b0, 1'b0); idle(3); check_state("R5 R7 drain full"); end
        rd_cycle(1'b0, 1'b0); idle(3); check_state("R6 read after drain");

        // Threshold mode
        do_reset(1'b0);
        check_state("R1 threshold mode");
        wr_cycle(1'b0, 1'b0, 9'd3);  idle(3); check_state("R3 load no store");
        wr_cycle(1'b0, 1'b0, 9'd10); idle(3); check_state("R4 second load full");
        for (int i = 0; i < DEPTH; i++) begin
            wr_cycle(1'b0, 1'b1, DW'($urandom)); idle(3);
            check_state("R3 R4 R8 R9 loaded");
        end
        wr_cycle(1'b0, 1'b0, 9'd250); idle(3); check_state("R4 wrap to empty");
        for (int i = 0; i < 8; i++) begin rd_cycle(1'b0, 1'b0); idle(3); check_state("R8 loaded 250"); end
        wr_cycle(1'b0, 1'b0, 9'd0); idle(3); check_state("R4 full threshold zero");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule